// File: doc/BRIEF.md
# DDR Power-Down and Clock-Change Sequencer

This controller-side block owns the clock-enable pin and the command bus of a DDR SDRAM. It takes the memory into low-power standby and brings it back out. It also makes a change of the input clock frequency safe. Power-down is requested and released with level requests. A status input reports whether every bank is precharged, and a second input reports whether a burst is still in flight. The bank status sampled when clock-enable falls decides the kind of power-down: precharged or active.

A frequency change is only granted from precharged power-down, and only after clock-enable has been held low for a minimum dwell. While the grant is up, clock-enable stays low. The exit waits for an external clock-stable flag. After the exit, the block sends one NOP. It then writes the extended mode register with a DLL reset word and inserts a gap of NOPs. Next it writes the regular mode register with a caller-supplied word that carries the new CAS latency. Finally it waits a relock interval before it reports ready again. An exit from active power-down sends only the NOP and then returns straight to ready.

Top module: `ddr_pd_seq`

## Requirements
- R1: After reset, `cke` is 1, `ready` is 1, `clk_may_change` is 0 and `cmd` is NOP. The command codes are NOP=0, MRS=1 and EMRS=2.
- R2: When `pd_enter_req` is sampled with `burst_active` low while ready, `cke` is 0 and `ready` is 0 in the next cycle. While `burst_active` is high, `cke` stays 1 and the entry is deferred until the burst ends.
- R3: `clk_may_change` rises only for a power-down entered with `banks_idle` high. It needs `freq_chg_req`, and it never rises before `cke` has been low for MIN_DWELL+1 cycles. If the request is held from entry, it is 1 in the (MIN_DWELL+2)-th low cycle. Once set, it stays set until the exit.
- R4: In an active power-down (entered with `banks_idle` low), `freq_chg_req` has no effect: `clk_may_change` stays 0. An exit request, even with `clk_stable` low, gives one NOP cycle with `cke` high and then `ready`.
- R5: In the first cycle in which `cke` is high after power-down, `cmd` is NOP.
- R6: While a frequency change is granted and `clk_stable` is low, an exit request is held and `cke` stays 0. The exit proceeds in the cycle after `clk_stable` is sampled high.
- R7: After a frequency-change exit, the commands run in this order: NOP, then EMRS (`ba`=1, `addr`=EMRS_WORD), then MRS_GAP NOPs, then MRS (`ba`=0, `addr`=`mode_word`), then RELOCK_CYC NOP cycles with `ready` low, then `ready`=1.
- R8: EMRS and MRS appear on `cmd` only while `banks_idle` is high. While it is low, NOP is driven and the pending command waits.
- R9: `clk_may_change` is never 1 while `cke` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_enter_req | input | 1 | Level request to enter power-down |
| pd_exit_req | input | 1 | Level request to leave power-down |
| freq_chg_req | input | 1 | Level request for a clock frequency change |
| banks_idle | input | 1 | All banks are precharged |
| burst_active | input | 1 | A read or write burst is in progress |
| clk_stable | input | 1 | The new input clock is stable |
| mode_word | input | ADDR_W | Regular mode register payload (carries the CAS latency) |
| cke | output | 1 | Clock enable to the memory |
| cmd | output | 2 | Command code: 0 NOP, 1 MRS, 2 EMRS |
| ba | output | BA_W | Bank bits; 0 selects the regular register, 1 the extended one |
| addr | output | ADDR_W | Address bits carrying the register payload |
| ready | output | 1 | The memory is up and free for normal traffic |
| clk_may_change | output | 1 | The input clock may now be changed |

## Verification
Two pairs of events can fall in the same cycle here. The first is a register-write slot arriving while the banks report busy. The bench drops `banks_idle` for a random number of cycles exactly when the EMRS or the MRS is due. It then judges that NOP is driven throughout and that the write appears in the cycle `banks_idle` returns. The second is an exit request meeting a clock-stable flag that is still low. The bench holds the exit for a random number of cycles and checks that `cke` stays low. It then checks that the exit NOP follows exactly one edge after `clk_stable` rises.

// File: rtl/ddr_pd_pkg.sv
package ddr_pd_pkg;

   typedef enum logic [1:0] {
      CMD_NOP  = 2'd0,
      CMD_MRS  = 2'd1,
      CMD_EMRS = 2'd2
   } ddr_cmd_e;

   typedef enum logic [2:0] {
      ST_RDY,
      ST_PD,
      ST_XNOP,
      ST_EMRS,
      ST_GAP,
      ST_MRS,
      ST_RELOCK
   } pd_state_e;

endpackage

// File: rtl/ddr_pd_dwell.sv
module ddr_pd_dwell #(
   parameter int MIN_DWELL = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_pd,
   output logic dwell_ok
);
   localparam int CW = $clog2(MIN_DWELL + 1);
   localparam logic [CW-1:0] LIMIT = CW'(MIN_DWELL);

   logic [CW-1:0] cnt_q;

   if (MIN_DWELL < 1) begin : g_bad_dwell
      $error("MIN_DWELL must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !in_pd)
         cnt_q <= '0;
      else if (cnt_q != LIMIT)
         cnt_q <= cnt_q + 1'b1;
   end

   assign dwell_ok = (cnt_q == LIMIT);

   a_r3_dwell_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !in_pd |=> !dwell_ok);
endmodule

// File: rtl/ddr_pd_timer.sv
module ddr_pd_timer #(
   parameter int MAX_CNT = 200
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic [$clog2(MAX_CNT+1)-1:0] load_val,
   input  logic                         run,
   output logic                         zero
);
   localparam int CW = $clog2(MAX_CNT + 1);

   logic [CW-1:0] cnt_q;

   if (MAX_CNT < 1) begin : g_bad_max
      $error("MAX_CNT must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (run && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   a_r7_timer_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ddr_pd_cmdgen.sv
module ddr_pd_cmdgen
   import ddr_pd_pkg::*;
#(
   parameter int              ADDR_W    = 12,
   parameter int              BA_W      = 2,
   parameter logic [ADDR_W-1:0] EMRS_WORD = 12'h100,
   parameter bit              PARK_ADDR = 1'b1
) (
   input  pd_state_e         state,
   input  logic              banks_idle,
   input  logic [ADDR_W-1:0] mode_word,
   output ddr_cmd_e          cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              fire
);
   localparam logic [BA_W-1:0] BA_REGULAR  = BA_W'(0);
   localparam logic [BA_W-1:0] BA_EXTENDED = BA_W'(1);

   logic              is_ext;
   logic [ADDR_W-1:0] payload;

   if (BA_W < 1) begin : g_bad_ba
      $error("BA_W must be at least 1");
   end

   always_comb begin
      is_ext = (state == ST_EMRS);
      fire   = ((state == ST_EMRS) || (state == ST_MRS)) && banks_idle;
      cmd    = CMD_NOP;
      if (fire)
         cmd = is_ext ? CMD_EMRS : CMD_MRS;
      payload = is_ext ? EMRS_WORD : mode_word;
      ba      = is_ext ? BA_EXTENDED : BA_REGULAR;
   end

   if (PARK_ADDR) begin : g_park
      assign addr = fire ? payload : '0;
   end else begin : g_pass
      assign addr = payload;
   end
endmodule

// File: rtl/ddr_pd_seq.sv
module ddr_pd_seq
   import ddr_pd_pkg::*;
#(
   parameter int                ADDR_W     = 12,
   parameter int                BA_W       = 2,
   parameter int                MIN_DWELL  = 2,
   parameter int                MRS_GAP    = 1,
   parameter int                RELOCK_CYC = 200,
   parameter logic [ADDR_W-1:0] EMRS_WORD  = 12'h100,
   parameter bit                PARK_ADDR  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd_enter_req,
   input  logic              pd_exit_req,
   input  logic              freq_chg_req,
   input  logic              banks_idle,
   input  logic              burst_active,
   input  logic              clk_stable,
   input  logic [ADDR_W-1:0] mode_word,
   output logic              cke,
   output logic [1:0]        cmd,
   output logic [BA_W-1:0]   ba,
   output logic [ADDR_W-1:0] addr,
   output logic              ready,
   output logic              clk_may_change
);
   localparam int TMAX = (RELOCK_CYC > MRS_GAP) ? RELOCK_CYC : MRS_GAP;
   localparam int TW   = $clog2(TMAX + 1);

   if (MRS_GAP < 1) begin : g_bad_gap
      $error("MRS_GAP must be at least 1");
   end
   if (RELOCK_CYC < 1) begin : g_bad_relock
      $error("RELOCK_CYC must be at least 1");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W must cover A0..A11");
   end

   pd_state_e state_q, state_d;
   logic      pre_kind_q;
   logic      fc_pend_q;
   logic      dwell_ok;
   logic      tmr_load, tmr_run, tmr_zero;
   logic [TW-1:0] tmr_val;
   logic      fire;
   ddr_cmd_e  cmd_e;

   ddr_pd_dwell #(.MIN_DWELL(MIN_DWELL)) u_dwell (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_pd    (state_q == ST_PD),
      .dwell_ok (dwell_ok)
   );

   ddr_pd_timer #(.MAX_CNT(TMAX)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .run      (tmr_run),
      .zero     (tmr_zero)
   );

   ddr_pd_cmdgen #(
      .ADDR_W    (ADDR_W),
      .BA_W      (BA_W),
      .EMRS_WORD (EMRS_WORD),
      .PARK_ADDR (PARK_ADDR)
   ) u_cmdgen (
      .state      (state_q),
      .banks_idle (banks_idle),
      .mode_word  (mode_word),
      .cmd        (cmd_e),
      .ba         (ba),
      .addr       (addr),
      .fire       (fire)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_RDY:    if (pd_enter_req && !burst_active) state_d = ST_PD;
         ST_PD:     if (pd_exit_req && (!fc_pend_q || clk_stable)) state_d = ST_XNOP;
         ST_XNOP:   state_d = fc_pend_q ? ST_EMRS : ST_RDY;
         ST_EMRS:   if (fire) begin
                       state_d  = ST_GAP;
                       tmr_load = 1'b1;
                       tmr_val  = TW'(MRS_GAP - 1);
                    end
         ST_GAP:    if (tmr_zero) state_d = ST_MRS;
         ST_MRS:    if (fire) begin
                       state_d  = ST_RELOCK;
                       tmr_load = 1'b1;
                       tmr_val  = TW'(RELOCK_CYC - 1);
                    end
         ST_RELOCK: if (tmr_zero) state_d = ST_RDY;
         default:   state_d = ST_RDY;
      endcase
   end

   assign tmr_run = (state_q == ST_GAP) || (state_q == ST_RELOCK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_RDY;
         pre_kind_q <= 1'b0;
         fc_pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_RDY && state_d == ST_PD)
            pre_kind_q <= banks_idle;
         if (state_d == ST_RDY)
            fc_pend_q <= 1'b0;
         else if (state_q == ST_PD && pre_kind_q && freq_chg_req && dwell_ok)
            fc_pend_q <= 1'b1;
      end
   end

   assign cke            = (state_q != ST_PD);
   assign ready          = (state_q == ST_RDY);
   assign clk_may_change = (state_q == ST_PD) && fc_pend_q;
   assign cmd            = cmd_e;

   a_r1_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (cke && cmd == CMD_NOP));
   a_r2_no_entry_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke) |-> !$past(burst_active));
   a_r5_exit_nop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke) |-> (cmd == CMD_NOP));
   a_r6_hold_until_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke && clk_may_change && !clk_stable) |=> !cke);
   a_r8_mrs_banks_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd != CMD_NOP) |-> banks_idle);
   a_r9_grant_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
      clk_may_change |-> !cke);
   a_r3_grant_after_dwell: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_may_change) |-> $past(dwell_ok));
endmodule

// File: tb/ddr_pd_seq_tb.sv
module ddr_pd_seq_tb_top;
   localparam int          AW     = 12;
   localparam int          DWELL  = 2;
   localparam int          GAP    = 1;
   localparam int          RELOCK = 200;
   localparam logic [11:0] EW     = 12'h100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pd_enter_req = 0, pd_exit_req = 0, freq_chg_req = 0;
   logic banks_idle = 1, burst_active = 0, clk_stable = 0;
   logic [AW-1:0] mode_word = '0;
   logic cke, ready, clk_may_change;
   logic [1:0] cmd;
   logic [1:0] ba;
   logic [AW-1:0] addr;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   always #4 clk = ~clk;

   ddr_pd_seq #(
      .ADDR_W(AW), .BA_W(2), .MIN_DWELL(DWELL), .MRS_GAP(GAP),
      .RELOCK_CYC(RELOCK), .EMRS_WORD(EW), .PARK_ADDR(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .pd_enter_req(pd_enter_req),
      .pd_exit_req(pd_exit_req), .freq_chg_req(freq_chg_req),
      .banks_idle(banks_idle), .burst_active(burst_active),
      .clk_stable(clk_stable), .mode_word(mode_word), .cke(cke),
      .cmd(cmd), .ba(ba), .addr(addr), .ready(ready),
      .clk_may_change(clk_may_change)
   );

   function automatic int exp_grant_cycle(input int dwell);
      return dwell + 2;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_fc(input logic [11:0] mw, input int st_e, input int st_m, input int hold);
      int bad;
      banks_idle = 1; burst_active = 0; pd_enter_req = 1; freq_chg_req = 1;
      tick;
      chk("R2 cke low after entry", cke, 0);
      chk("R2 ready low in power-down", ready, 0);
      pd_enter_req = 0;
      for (int k = 1; k < exp_grant_cycle(DWELL); k++) begin
         chk("R3 no grant before dwell", clk_may_change, 0);
         tick;
      end
      chk("R3 grant after dwell", clk_may_change, 1);
      freq_chg_req = 0;
      mode_word = mw; pd_exit_req = 1; clk_stable = 0;
      for (int k = 0; k < hold; k++) begin
         tick;
         chk("R6 exit held while clock unstable", cke, 0);
         chk("R3 grant kept until exit", clk_may_change, 1);
      end
      clk_stable = 1;
      tick;
      chk("R5 cke high after exit", cke, 1);
      chk("R5 NOP on exit cycle", cmd, 0);
      chk("R9 grant dropped with cke high", clk_may_change, 0);
      pd_exit_req = 0; clk_stable = 0;
      banks_idle = (st_e == 0);
      tick;
      for (int k = 0; k < st_e; k++) begin
         chk("R8 EMRS withheld while banks busy", cmd, 0);
         tick;
      end
      banks_idle = 1; #1;
      chk("R7 EMRS command", cmd, 2);
      chk("R7 EMRS bank bits", ba, 1);
      chk("R7 EMRS payload", addr, EW);
      tick;
      chk("R7 NOP gap after EMRS", cmd, 0);
      for (int k = 1; k < GAP; k++) tick;
      banks_idle = (st_m == 0);
      tick;
      for (int k = 0; k < st_m; k++) begin
         chk("R8 MRS withheld while banks busy", cmd, 0);
         tick;
      end
      banks_idle = 1; #1;
      chk("R7 MRS command", cmd, 1);
      chk("R7 MRS bank bits", ba, 0);
      chk("R7 MRS payload", addr, mw);
      bad = 0;
      for (int k = 0; k < RELOCK; k++) begin
         tick;
         if (ready !== 1'b0 || cmd !== 2'd0 || cke !== 1'b1) bad++;
      end
      chk("R7 relock window NOP and not ready", bad, 0);
      tick;
      chk("R7 ready after relock", ready, 1);
   endtask

   task automatic do_active(input int dwell_cyc);
      banks_idle = 0; pd_enter_req = 1;
      tick;
      chk("R2 cke low active entry", cke, 0);
      pd_enter_req = 0; freq_chg_req = 1; banks_idle = 1;
      for (int k = 0; k < dwell_cyc; k++) tick;
      chk("R4 no grant in active power-down", clk_may_change, 0);
      freq_chg_req = 0; pd_exit_req = 1; clk_stable = 0;
      tick;
      chk("R4 exit not held", cke, 1);
      chk("R5 NOP on active exit", cmd, 0);
      chk("R4 not ready on NOP cycle", ready, 0);
      pd_exit_req = 0;
      tick;
      chk("R4 ready after single NOP", ready, 1);
      chk("R4 no mode write", cmd, 0);
   endtask

   task automatic do_burst(input int len);
      burst_active = 1; pd_enter_req = 1;
      for (int k = 0; k < len; k++) begin
         tick;
         chk("R2 entry deferred during burst", cke, 1);
      end
      burst_active = 0;
      tick;
      chk("R2 entry after burst ends", cke, 0);
      pd_enter_req = 0; pd_exit_req = 1;
      tick;
      pd_exit_req = 0;
      tick;
      chk("R2 back to ready", ready, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R0 watchdog actual=1 expected=0");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) tick;
      chk("R1 cke in reset", cke, 1);
      rst_n = 1;
      tick;
      chk("R1 cke after reset", cke, 1);
      chk("R1 ready after reset", ready, 1);
      chk("R1 NOP after reset", cmd, 0);
      chk("R1 no grant after reset", clk_may_change, 0);

      do_fc(12'h032, 0, 0, 0);
      do_fc(12'h021, 2, 3, 4);
      do_active(3);
      do_burst(5);
      for (int it = 0; it < 5; it++) begin
         do_fc(12'($urandom), int'($urandom % 4), int'($urandom % 4), int'($urandom % 5));
         do_active(int'($urandom % 6));
         do_burst(int'($urandom % 4));
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule